// File: doc/BRIEF.md
# Serial Clock Wait and Interrupt Controller

This block handles interrupt timing and clock stretching for a two-wire serial port working in master or slave role. It watches the shared clock line through a synchroniser and counts the rising edges of each byte. At a chosen edge it raises an interrupt request. In the stretching modes it also pulls the open-drain clock line low, so the bus waits until software writes a release command.

Software uses one 8-bit control/status register for all of this. The register holds a two-bit mode field, a self-clearing release bit, a bit that sets the idle clock level, a sticky error bit for the forbidden mode code, and a read-only copy of the clock pin level. Shifting data, matching addresses and detecting start or stop conditions belong to neighbouring logic.

Top module: `sclk_wait_ctrl`

## Requirements
- R1: While reset is held, every stored register bit is 0 and `reg_rdata` reads 8'h00.
- R2: Bit 6 of `reg_rdata` shows the synchronised clock pin level. A write to bit 6 changes nothing.
- R3: Mode code 2'b00 (bits 1:0) gives one interrupt at the 8th rising clock edge of a byte and never holds the clock low.
- R4: Mode code 2'b01 acts exactly like 2'b00. Writing it also sets error bit 7, which stays at 1 until reset.
- R5: Mode code 2'b10 gives the interrupt at the 8th rising edge and asserts `scl_oe` in the same cycle as the interrupt. `scl_oe` then stays asserted as a wait.
- R6: Mode code 2'b11 behaves like 2'b10 but acts at the 9th rising edge.
- R7: Writing 1 to bit 2 (release) during a wait deasserts `scl_oe` from the next clock edge. Bit 2 reads back 0 once the wait is over.
- R8: With `xfer_active` low and no wait pending, `scl_oe` equals the inverse of bit 3: 0 holds the line low, 1 lets it float high.
- R9: The edge count restarts at each rising edge of `xfer_active` and stops at 9. Extra edges in the same byte raise no further interrupt.
- R10: `irq` is a pulse exactly one system clock wide. It comes three system clocks after the pin rises: two synchroniser flops, then the pulse register.
- R11: The role input `is_master` does not change the interrupt or wait timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| xfer_active | input | 1 | High while a byte transfer is in progress |
| scl_in | input | 1 | Sampled level of the clock pin |
| is_master | input | 1 | Role: 1 master, 0 slave |
| scl_oe | output | 1 | Open-drain drive enable; 1 pulls the clock line low |
| irq | output | 1 | Interrupt request pulse |

## Verification
In the stretching modes, the interrupt pulse and the start of the wait come from the same counted edge and appear in the same system clock. The bench drives a line model in which `scl_oe` overrides the master's drive. It records `scl_oe` in the very cycle the interrupt is seen and requires it to equal the mode's wait setting. The sweep covers all four mode codes, both roles and both idle levels. The bench also checks that pulses sent during the wait are swallowed and that the saturated counter raises no second interrupt.

// File: rtl/sclkw_pkg.sv
package sclkw_pkg;

   typedef enum logic [1:0] {
      WM_PLAIN = 2'b00,
      WM_BAD   = 2'b01,
      WM_HOLD8 = 2'b10,
      WM_HOLD9 = 2'b11
   } wmode_e;

   localparam int CTRL_W     = 8;
   localparam int F_MODE_LO  = 0;
   localparam int F_RELEASE  = 2;
   localparam int F_IDLE_LVL = 3;
   localparam int F_PIN      = 6;
   localparam int F_ERR      = 7;

   function automatic wmode_e effective_mode(input logic [1:0] raw);
      wmode_e m;
      m = wmode_e'(raw);
      if (m == WM_BAD) m = WM_PLAIN;
      return m;
   endfunction

   function automatic logic mode_holds(input wmode_e m);
      return (m == WM_HOLD8) || (m == WM_HOLD9);
   endfunction

endpackage

// File: rtl/sclkw_sync.sv
module sclkw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES-1];
   end

   assign q    = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sclkw_cnt.sv
module sclkw_cnt #(
   parameter int LIMIT = 9,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [CW-1:0] count,
   output logic          full
);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count <= '0;
      else if (clear)                 count <= '0;
      else if (step && count < LIM_V) count <= count + 1'b1;
   end

   assign full = (count >= LIM_V);
endmodule

// File: rtl/sclkw_regs.sv
module sclkw_regs
   import sclkw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              wait_on,
   input  logic              pin_level,
   output logic [1:0]        mode_raw,
   output logic              idle_lvl,
   output logic              release_req,
   output logic              err_flag,
   output logic [CTRL_W-1:0] rdata
);
   logic rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_raw <= 2'b00;
         idle_lvl <= 1'b0;
         err_flag <= 1'b0;
         rel_q    <= 1'b0;
      end else begin
         if (wr) begin
            mode_raw <= wdata[F_MODE_LO +: 2];
            idle_lvl <= wdata[F_IDLE_LVL];
            if (wmode_e'(wdata[F_MODE_LO +: 2]) == WM_BAD) err_flag <= 1'b1;
         end
         if (wr && wdata[F_RELEASE]) rel_q <= 1'b1;
         else if (!wait_on)          rel_q <= 1'b0;
      end
   end

   assign release_req = wr & wdata[F_RELEASE];

   always_comb begin
      rdata                   = '0;
      rdata[F_MODE_LO +: 2]   = mode_raw;
      rdata[F_RELEASE]        = rel_q;
      rdata[F_IDLE_LVL]       = idle_lvl;
      rdata[F_PIN]            = pin_level;
      rdata[F_ERR]            = err_flag;
   end

   logic [2:0] wdata_unused;
   assign wdata_unused = {wdata[7], wdata[5:4]} ^ {wdata[6], 2'b00};
endmodule

// File: rtl/sclk_wait_ctrl.sv
module sclk_wait_ctrl
   import sclkw_pkg::*;
#(
   parameter int BYTE_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [CTRL_W-1:0]      reg_wdata,
   output logic [CTRL_W-1:0]      reg_rdata,
   input  logic                   xfer_active,
   input  logic                   scl_in,
   input  logic                   is_master,
   output logic                   scl_oe,
   output logic                   irq
);
   localparam int EDGE_MAX = BYTE_BITS + 1;
   localparam int CW       = $clog2(EDGE_MAX + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BYTE_BITS < 2) begin : g_bad_bits
         $error("BYTE_BITS must be at least 2");
      end
   endgenerate

   logic          pin_s, pin_rise;
   logic          xa_q, byte_start;
   logic [CW-1:0] cnt_q;
   logic          cnt_full;
   logic          step, hit;
   logic [1:0]    mode_q;
   logic          clc_q, rel_pulse, err_q;
   logic          wait_q, irq_q;
   wmode_e        mode_eff;
   logic [CW-1:0] target;

   sclkw_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(pin_s), .rise(pin_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) xa_q <= 1'b0;
      else        xa_q <= xfer_active;
   end
   assign byte_start = xfer_active & ~xa_q;

   assign step = pin_rise & xfer_active & ~byte_start;

   sclkw_cnt #(.LIMIT(EDGE_MAX), .CW(CW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clear(byte_start), .step(step),
      .count(cnt_q), .full(cnt_full)
   );

   sclkw_regs regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .wait_on(wait_q), .pin_level(pin_s), .mode_raw(mode_q),
      .idle_lvl(clc_q), .release_req(rel_pulse), .err_flag(err_q),
      .rdata(reg_rdata)
   );

   assign mode_eff = effective_mode(mode_q);
   assign target   = (mode_eff == WM_HOLD9) ? CW'(BYTE_BITS + 1) : CW'(BYTE_BITS);
   assign hit      = step && !cnt_full && ((cnt_q + 1'b1) == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         irq_q <= hit;
         if (wait_q && rel_pulse)            wait_q <= 1'b0;
         else if (hit && mode_holds(mode_eff)) wait_q <= 1'b1;
      end
   end

   assign irq    = irq_q;
   assign scl_oe = wait_q | (~xfer_active & ~clc_q);

   logic role_unused;
   assign role_unused = is_master;
endmodule

// File: rtl/sclkw_chk.sv
module sclkw_chk #(
   parameter int CW       = 4,
   parameter int EDGE_MAX = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq,
   input logic          scl_oe,
   input logic          reg_wr,
   input logic [7:0]    reg_wdata,
   input logic          wait_q,
   input logic          err_q,
   input logic [CW-1:0] cnt_q,
   input logic [1:0]    mode_q
);
   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R5
   hold_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && mode_q[1]) |-> scl_oe);

   // R7
   release_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && reg_wr && reg_wdata[2]) |=> !wait_q);

   // R7
   wait_only_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_q) |-> $past(reg_wr && reg_wdata[2]));

   // R4
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R9
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(EDGE_MAX));
endmodule

bind sclk_wait_ctrl sclkw_chk #(.CW(CW), .EDGE_MAX(EDGE_MAX)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .wait_q(wait_q),
   .err_q(err_q), .cnt_q(cnt_q), .mode_q(mode_q)
);

// File: tb/sclk_wait_ctrl_tb.sv
module sclk_wait_ctrl_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       xfer_active = 1'b0;
   logic       drv = 1'b0;
   logic       is_master = 1'b0;
   logic       scl_oe, irq, line;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   int irq_n = 0;
   int irq_at = 0;
   int oe_at_irq = 0;
   int irq_run = 0;
   int irq_wide = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign line = drv & ~scl_oe;

   sclk_wait_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .xfer_active(xfer_active), .scl_in(line),
      .is_master(is_master), .scl_oe(scl_oe), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq) begin
         irq_n++;
         irq_at    = pulses;
         oe_at_irq = scl_oe;
         irq_run++;
         if (irq_run > 1) irq_wide++;
      end else begin
         irq_run = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse();
      drv = 1'b1;
      pulses++;
      repeat (4) @(negedge clk);
      drv = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic new_byte();
      drv = 1'b0;
      xfer_active = 1'b0;
      repeat (2) @(negedge clk);
      xfer_active = 1'b1;
      repeat (2) @(negedge clk);
      pulses = 0;
      irq_n = 0;
      irq_at = 0;
   endtask

   task automatic run_cfg(input int m, input int role, input int clc);
      logic [7:0] cfg;
      int target, holds;
      cfg    = 8'(m) | (clc != 0 ? 8'h08 : 8'h00);
      target = (m == 3) ? 9 : 8;
      holds  = (m >= 2) ? 1 : 0;
      is_master = role[0];
      drv = 1'b0;
      xfer_active = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset read", reg_rdata, 0);
      rst_n = 1'b1;
      wr_reg(cfg);
      @(negedge clk);
      chk("R8 idle level", scl_oe, clc != 0 ? 0 : 1);
      chk("R4 mode readback", reg_rdata[1:0], m);
      chk("R4 error bit", reg_rdata[7], m == 1 ? 1 : 0);

      new_byte();
      for (int p = 0; p < 11; p++) pulse();
      // R3 R5 R6 R11: one interrupt at target edge, independent of role
      chk($sformatf("R3/R5/R6 irq count role=%0d", role), irq_n, 1);
      chk("R6 irq edge", irq_at, target);
      chk("R5 oe with irq", oe_at_irq, holds);
      chk("R9 hold after pulses", scl_oe, holds);
      chk("R10 irq width", irq_wide, 0);

      wr_reg(cfg | 8'h40);
      repeat (3) @(negedge clk);
      chk("R2 pin low ignores write", reg_rdata[6], 0);

      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = cfg | 8'h04;
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R7 release drop", scl_oe, 0);
      repeat (2) @(negedge clk);
      chk("R7 release bit clear", reg_rdata[2], 0);

      pulse();
      drv = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 pin high", reg_rdata[6], 1);
      chk("R9 no retrigger", irq_n, 1);

      new_byte();
      for (int p = 0; p < 10; p++) pulse();
      chk("R9 restart count", irq_n, 1);
      chk("R9 restart edge", irq_at, target);
      chk("R4 sticky error", reg_rdata[7], m == 1 ? 1 : 0);
   endtask

   initial begin
      for (int m = 0; m < 4; m++)
         for (int r = 0; r < 2; r++)
            for (int c = 0; c < 2; c++)
               run_cfg(m, r, c);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule